// File: doc/BRIEF.md
# Bidirectional Port Data Register

This block holds the data for a 16-bit general-purpose pin port. Each bit belongs to one pad and is set to act as a general input or a general output by a direction vector. That vector comes from a separate control block. For an output bit, the stored value drives the pad and reads return the stored value. For an input bit, reads return the pad level after a two-flop synchronizer, and writes still load the stored bit without reaching the pad.

A small bus engine serves byte and halfword accesses. Each access takes exactly two cycles. In the first cycle (state `S_IDLE`) a request is accepted and latched. The engine then moves to the second cycle (state `S_ACK`), where `ready` is high, read data is presented, and a write commits on the closing clock edge. After that the engine always returns to `S_IDLE`.

An active-low output-disable input forces every pad enable low and leaves the stored data alone. A non-watchdog power-on reset clears the register, and so does hardware standby. A watchdog-sourced power-on reset leaves the register intact. The other low-power modes are not visible to the block and so cannot touch the register.

Top module: `gpio_port_data`

## Requirements
- R1: While a power-on reset is active, the register is cleared: after release `pad_out` reads 0x0000, `ready` is low and `pad_oe` is 0 for input bits.
- R2: Every access, byte or halfword, raises `ready` for exactly one cycle. That cycle follows the cycle in which `req` was accepted, and `rdata` is valid in it.
- R3: A halfword write (`size16`=1) loads all 16 bits from `wdata`. Bits whose `dir` is 1 (output) then drive the new value on `pad_out` with `pad_oe` high.
- R4: A byte write (`size16`=0) takes its data from `wdata[7:0]`. `lane`=1 selects bits 15..8 and `lane`=0 selects bits 7..0. The other byte is unchanged.
- R5: A read returns the stored bit for every output bit, whatever the level on `pad_in`.
- R6: A read returns the `pad_in` level, delayed by two clock edges, for every input bit. A byte read returns the selected byte in `rdata[7:0]` with `rdata[15:8]` zero.
- R7: A write to an input bit stores the value, and the stored value is visible once the bit becomes an output. `pad_oe` stays 0 for every bit whose `dir` is 0.
- R8: While `out_dis_n` is 0, all of `pad_oe` is 0 and the register keeps accepting writes. When `out_dis_n` returns to 1, the stored values are driven again.
- R9: `por`=1 with `por_wdt`=0 clears the register on the next edge, and this takes priority over a write committing in the same cycle.
- R10: `por`=1 with `por_wdt`=1 leaves the register contents unchanged.
- R11: `hw_stby`=1 clears the register on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset for the bus engine and the synchronizer |
| por | input | 1 | Power-on reset in progress |
| por_wdt | input | 1 | The power-on reset was raised by the watchdog |
| hw_stby | input | 1 | Hardware standby active |
| req | input | 1 | Access request, held until `ready` |
| wr | input | 1 | 1 = write, 0 = read |
| size16 | input | 1 | 1 = halfword, 0 = byte |
| lane | input | 1 | Byte select: 1 = bits 15..8, 0 = bits 7..0 |
| wdata | input | 16 | Write data; byte writes use bits 7..0 |
| ready | output | 1 | High in the second cycle of an access |
| rdata | output | 16 | Read data, valid while `ready` is high |
| dir | input | 16 | Per-bit function: 1 = general output, 0 = general input |
| out_dis_n | input | 1 | Active-low output disable for all pads |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output data (the stored register) |
| pad_oe | output | 16 | Pad output enables |

## Verification
Two events can land on the same clock edge: a write committing at the end of `S_ACK`, and a register clear from a non-watchdog power-on reset. The bench provokes this by raising `por` during the `ready` cycle of a halfword write. It then expects `pad_out` to read 0x0000 after the edge, so the clear wins over the write. A second overlap is a write issued while `out_dis_n` is low. There the bench checks that the pads stay disabled during the write and that the written value appears once the disable is lifted.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } bus_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int LANES  = WIDTH / 8,
    parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic              size16,
    input  logic [LANE_W-1:0] lane,
    input  logic [WIDTH-1:0]  wdata,
    output logic              ready,
    output logic [LANES-1:0]  wr_lane,
    output logic [WIDTH-1:0]  wr_data,
    output logic              rd_full,
    output logic [LANE_W-1:0] rd_lane
);
    bus_state_t        state;
    logic              c_wr;
    logic              c_full;
    logic [LANE_W-1:0] c_lane;
    logic [WIDTH-1:0]  c_data;

    // state register and command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            c_wr   <= 1'b0;
            c_full <= 1'b0;
            c_lane <= '0;
            c_data <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req) begin
                    state  <= S_ACK;
                    c_wr   <= wr;
                    c_full <= size16;
                    c_lane <= lane;
                    c_data <= size16 ? wdata : {LANES{wdata[7:0]}};
                end
                S_ACK: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        wr_lane = '0;
        unique case (state)
            S_IDLE: ready = 1'b0;
            S_ACK: begin
                ready = 1'b1;
                for (int l = 0; l < LANES; l++)
                    wr_lane[l] = c_wr && (c_full || (c_lane == LANE_W'(l)));
            end
            default: ready = 1'b0;
        endcase
    end

    assign wr_data = c_data;
    assign rd_full = c_full;
    assign rd_lane = c_lane;
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
    parameter int WIDTH = 16,
    parameter int LANES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [LANES-1:0] wr_lane,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (clr)
                    q[l*8 +: 8] <= 8'h00;
                else if (wr_lane[l])
                    q[l*8 +: 8] <= wr_data[l*8 +: 8];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LANES       = WIDTH / 8,
    parameter int LANE_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por,
    input  logic              por_wdt,
    input  logic              hw_stby,
    input  logic              req,
    input  logic              wr,
    input  logic              size16,
    input  logic [LANE_W-1:0] lane,
    input  logic [WIDTH-1:0]  wdata,
    output logic              ready,
    output logic [WIDTH-1:0]  rdata,
    input  logic [WIDTH-1:0]  dir,
    input  logic              out_dis_n,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    logic [LANES-1:0]  wr_lane;
    logic [WIDTH-1:0]  wr_data;
    logic              rd_full;
    logic [LANE_W-1:0] rd_lane;
    logic [WIDTH-1:0]  pin_sync;
    logic [WIDTH-1:0]  store;
    logic [WIDTH-1:0]  view;
    logic              clr;

    gpio_bus_fsm #(.WIDTH(WIDTH), .LANES(LANES), .LANE_W(LANE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size16(size16),
        .lane(lane), .wdata(wdata), .ready(ready), .wr_lane(wr_lane),
        .wr_data(wr_data), .rd_full(rd_full), .rd_lane(rd_lane)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    // non-watchdog power-on reset or hardware standby wipes the data
    assign clr = (por && !por_wdt) || hw_stby;

    gpio_data_reg #(.WIDTH(WIDTH), .LANES(LANES)) u_reg (
        .clk(clk), .clr(clr), .wr_lane(wr_lane), .wr_data(wr_data), .q(store)
    );

    assign view = (dir & store) | (~dir & pin_sync);

    always_comb begin
        rdata = '0;
        if (ready) begin
            if (rd_full)
                rdata = view;
            else
                rdata[7:0] = view[rd_lane*8 +: 8];
        end
    end

    assign pad_out = store;
    assign pad_oe  = dir & {WIDTH{out_dis_n}};
endmodule

// File: rtl/gpio_port_data_chk.sv
module gpio_port_data_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por,
    input logic             por_wdt,
    input logic             hw_stby,
    input logic             req,
    input logic             ready,
    input logic [WIDTH-1:0] dir,
    input logic             out_dis_n,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    assert_ready_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |=> ready);
    assert_oe_in_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir) == '0);
    assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_dis_n |-> (pad_oe == '0));
    assert_por_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (por && !por_wdt) |=> (pad_out == '0));
    assert_wdt_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (por && por_wdt && !hw_stby && !ready) |=> $stable(pad_out));
    assert_stby_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pad_out == '0));
endmodule

bind gpio_port_data gpio_port_data_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .por(por), .por_wdt(por_wdt), .hw_stby(hw_stby),
    .req(req), .ready(ready), .dir(dir), .out_dis_n(out_dis_n),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_port_data.sv
module tb_gpio_port_data;
    logic        clk = 1'b0;
    logic        rst_n, por, por_wdt, hw_stby;
    logic        req, wr, size16;
    logic [0:0]  lane;
    logic [15:0] wdata, rdata, dir, pad_in, pad_out, pad_oe;
    logic        ready, out_dis_n;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [15:0] mdl;

    logic [15:0] q_exp [$];
    bit          q_chk [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    gpio_port_data dut (
        .clk(clk), .rst_n(rst_n), .por(por), .por_wdt(por_wdt), .hw_stby(hw_stby),
        .req(req), .wr(wr), .size16(size16), .lane(lane), .wdata(wdata),
        .ready(ready), .rdata(rdata), .dir(dir), .out_dis_n(out_dis_n),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per ready pulse
    always @(negedge clk) begin
        if (rst_n && ready === 1'b1) begin
            if (q_exp.size() == 0) begin
                check("R2 unexpected ready", 16'h1, 16'h0);
            end else begin
                logic [15:0] e;
                bit c;
                string t;
                e = q_exp.pop_front();
                c = q_chk.pop_front();
                t = q_tag.pop_front();
                if (c) check(t, rdata, e);
            end
        end
    end

    function automatic logic [15:0] view(logic [15:0] pins);
        return (dir & mdl) | (~dir & pins);
    endfunction

    // driver: one access, pushes the expectation, updates the model
    task automatic access(bit w, bit full, bit ln, logic [15:0] d,
                          string tag, bit clear_in_ack);
        logic [15:0] e;
        e = view(pad_in);
        if (!full) e = ln ? {8'h00, e[15:8]} : {8'h00, e[7:0]};
        q_exp.push_back(e);
        q_chk.push_back(!w);
        q_tag.push_back(tag);
        @(negedge clk);
        req = 1'b1; wr = w; size16 = full; lane = ln; wdata = d;
        check("R2 ready low in first cycle", {15'h0, ready}, 16'h0);
        @(negedge clk);
        check("R2 ready high in second cycle", {15'h0, ready}, 16'h1);
        req = 1'b0;
        if (clear_in_ack) begin por = 1'b1; por_wdt = 1'b0; end
        @(negedge clk);
        check("R2 ready single cycle", {15'h0, ready}, 16'h0);
        if (clear_in_ack) begin
            por = 1'b0;
            mdl = 16'h0;
        end else if (w) begin
            if (full) mdl = d;
            else if (ln) mdl[15:8] = d[7:0];
            else mdl[7:0] = d[7:0];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; por = 1; por_wdt = 0; hw_stby = 0;
        req = 0; wr = 0; size16 = 1; lane = 0; wdata = 0;
        dir = 16'h0000; out_dis_n = 1; pad_in = 16'h0000;
        mdl = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        por = 0;
        @(negedge clk);
        check("R1 reset pad_out", pad_out, 16'h0000);
        check("R1 reset pad_oe", pad_oe, 16'h0000);
        check("R1 reset ready", {15'h0, ready}, 16'h0);

        dir = 16'hFFFF;
        access(1, 1, 0, 16'hA5C3, "R3 write", 0);
        check("R3 pad_out", pad_out, 16'hA5C3);
        check("R3 pad_oe", pad_oe, 16'hFFFF);
        pad_in = 16'h5A3C;
        repeat (3) @(negedge clk);
        access(0, 1, 0, 16'h0, "R5 read outputs", 0);

        access(1, 0, 1, 16'h003C, "R4 byte write high", 0);
        check("R4 high byte", pad_out, 16'h3CC3);
        access(1, 0, 0, 16'hFF96, "R4 byte write low", 0);
        check("R4 low byte", pad_out, 16'h3C96);
        access(0, 0, 1, 16'h0, "R6 byte read high", 0);
        access(0, 0, 0, 16'h0, "R6 byte read low", 0);

        dir = 16'h00FF;
        pad_in = 16'hC300;
        @(negedge clk);
        check("R6 sync not yet", pad_out, 16'h3C96);
        repeat (2) @(negedge clk);
        access(0, 1, 0, 16'h0, "R6 R5 mixed read", 0);

        access(1, 1, 0, 16'h1234, "R7 write inputs", 0);
        check("R7 pad_oe only outputs", pad_oe, 16'h00FF);
        dir = 16'hFFFF;
        access(0, 1, 0, 16'h0, "R7 stored input bits", 0);

        out_dis_n = 0;
        @(negedge clk);
        check("R8 pads disabled", pad_oe, 16'h0000);
        access(1, 1, 0, 16'hBEEF, "R8 write while disabled", 0);
        check("R8 still disabled", pad_oe, 16'h0000);
        out_dis_n = 1;
        @(negedge clk);
        check("R8 re-enabled oe", pad_oe, 16'hFFFF);
        check("R8 re-enabled data", pad_out, 16'hBEEF);

        por = 1; por_wdt = 1;
        repeat (2) @(negedge clk);
        por = 0; por_wdt = 0;
        @(negedge clk);
        check("R10 watchdog reset keeps", pad_out, 16'hBEEF);

        hw_stby = 1;
        @(negedge clk);
        hw_stby = 0;
        mdl = 16'h0;
        check("R11 standby clears", pad_out, 16'h0000);

        access(1, 1, 0, 16'h7777, "R3 rewrite", 0);
        check("R3 rewrite value", pad_out, 16'h7777);
        access(1, 1, 0, 16'h1111, "R9 write vs clear", 1);
        check("R9 clear wins over write", pad_out, 16'h0000);
        access(0, 1, 0, 16'h0, "R9 read after clear", 0);

        repeat (3) @(negedge clk);
        check("R2 queue drained", 16'(q_exp.size()), 16'h0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule